// File: doc/BRIEF.md
# PHY Management Register Bank

This block holds the management registers of a physical-layer transceiver. A serial management slave, outside this block, decodes frames and presents a parallel 5-bit register address, a 16-bit write word and one-cycle read and write strobes. The bank answers with read data from the addressed register, in the same cycle as the address, and a flag that tells the slave whether the address is implemented. Unimplemented addresses are ignored, so the slave can drop the transaction.

Six registers are implemented: a basic control word, a basic status word, two identifier words, an extended control word and a summary status word. Every bit has its own access class:
- read-only
- read/write
- write-zero-only
- command-override
- latching-low
- latching-high
- self-clearing

Control fields that come from pins are loaded from strap inputs during reset. The stored control words are also driven out to the rest of the device.

Top module: `mgmt_reg_bank`

## Requirements
- R1: `addr_valid` is 1 exactly for addresses 0, 1, 2, 3, 16 and 17. For any other address `rdata` is zero, and a write changes no register.
- R2: Read-only fields keep their value under any write. These are the identifier words at address 2 (`ID_HI`) and address 3 (`ID_LO`), and the capability field at address 1 bits 15:11 (`ABILITY`).
- R3: Address 0 bit 12 (auto-negotiation enable) is command-override. A write to address 0 updates it only if address 16 bit 15 (override) was already 1 before the write cycle. Otherwise it keeps its value.
- R4: Read/write bits store any written value. These are address 0 bits 14, 13 and 8, and address 16 bits 15 and 7:0. The write-zero-only bits, address 0 bit 7 and address 16 bit 11, always read 0.
- R5: Latching-low link bits are address 1 bit 2 and address 17 bit 0; both follow `link_up`. Each goes to 0 when `link_up` is low and stays 0 until its own register is read. The read returns the held value. After the read the bit follows `link_up` again.
- R6: Latching-high fault bits are address 1 bit 4 (following `rem_fault`) and address 17 bit 1 (following `jabber`). Each goes to 1 when its input is high and stays 1 until its register is read, then follows its input again.
- R7: Self-clearing bits are address 0 bit 15 and bit 9. A write of 1 sets the bit for exactly `SC_CYCLES` cycles, after which it returns to 0 with no further write. A new write of 1 during the countdown restarts it, and a write of 0 does not clear it.
- R8: Reset values of address 0 are: bit 13 = `strap_speed`, bit 12 = `strap_aneg`, bit 8 = `strap_duplex`, all other bits 0. Address 16 resets to 0. The latching-low bits reset to 1 and the latching-high bits reset to 0.
- R9: `rdata` reflects `addr` in the same cycle, without waiting for a clock edge. Live status bits (address 1 bit 5 and address 17 bits 15:14) show `aneg_done` and `link_up` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, marks the cycle in which read data is taken |
| rdata | output | 16 | Read data of the addressed register |
| addr_valid | output | 1 | Address is implemented |
| link_up | input | 1 | Live link condition |
| rem_fault | input | 1 | Live remote fault condition |
| jabber | input | 1 | Live jabber condition |
| aneg_done | input | 1 | Live auto-negotiation complete |
| strap_speed | input | 1 | Strap for speed select reset value |
| strap_duplex | input | 1 | Strap for duplex reset value |
| strap_aneg | input | 1 | Strap for auto-negotiation enable reset value |
| ctl_word | output | 16 | Current basic control word |
| ext_word | output | 16 | Current extended control word |

## Verification
Two things can fall in the same cycle: a latching bit's condition can change in the very cycle in which its register is being read. The bench provokes this directly. It drops `link_up` and raises `rem_fault` in the read cycle itself, and it also lets the random phase toggle the status inputs while reads hit addresses 1 and 17. The bench model checks two results. The read must return the value held before that edge. The next read must show the new condition, so the event is delayed by one read but never lost.

// File: rtl/mgmt_rb_pkg.sv
// Package: shared addresses, bit positions and per-class masks for the
// management register bank. Assumes a 5-bit address and 16-bit data word.
package mgmt_rb_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    // Implemented register addresses
    localparam logic [ADDR_W-1:0] A_CTL  = 5'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 5'd1;
    localparam logic [ADDR_W-1:0] A_IDH  = 5'd2;
    localparam logic [ADDR_W-1:0] A_IDL  = 5'd3;
    localparam logic [ADDR_W-1:0] A_EXT  = 5'd16;
    localparam logic [ADDR_W-1:0] A_SUM  = 5'd17;

    // Register select decoded from the address
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTL,
        SEL_STAT,
        SEL_IDH,
        SEL_IDL,
        SEL_EXT,
        SEL_SUM
    } reg_sel_e;

    // Basic control word bit positions
    localparam int CTL_SPEED = 13;
    localparam int CTL_ANEN  = 12;
    localparam int CTL_DUP   = 8;

    // Per-class masks of the basic control word
    localparam logic [DATA_W-1:0] CTL_RW_MASK = 16'h6100;
    localparam logic [DATA_W-1:0] CTL_CW_MASK = 16'h1000;
    localparam logic [DATA_W-1:0] CTL_SC_MASK = 16'h8200;

    // Extended control word
    localparam int EXT_OVR = 15;
    localparam logic [DATA_W-1:0] EXT_RW_MASK = 16'h80FF;

    // Latch slots: 0 stat link, 1 stat fault, 2 summary link, 3 summary jabber
    localparam int N_LAT = 4;
    localparam logic [N_LAT-1:0] LAT_HOLD_LOW = 4'b0101;

endpackage

// File: rtl/mgmt_rb_decode.sv
// Address decoder: maps the 5-bit register address onto a register select
// and flags whether the address is implemented. Purely combinational.
module mgmt_rb_decode
    import mgmt_rb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic              valid
);

    // Pick the register addressed, SEL_NONE for holes in the map
    always_comb begin
        case (addr)
            A_CTL:   sel = SEL_CTL;
            A_STAT:  sel = SEL_STAT;
            A_IDH:   sel = SEL_IDH;
            A_IDL:   sel = SEL_IDL;
            A_EXT:   sel = SEL_EXT;
            A_SUM:   sel = SEL_SUM;
            default: sel = SEL_NONE;
        endcase
    end

    // Implemented flag follows the select
    always_comb valid = (sel != SEL_NONE);

endmodule

// File: rtl/mgmt_rb_latch.sv
// Event latch for one status bit. HOLD_LOW=1 latches a low condition,
// HOLD_LOW=0 latches a high one. The held value remains visible until a
// read of the owning register (rd_clr); on that edge the bit reloads the
// live condition. Assumes rd_clr is a one-cycle strobe.
module mgmt_rb_latch #(
    parameter bit HOLD_LOW = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic rd_clr,
    output logic q
);

    localparam logic RST_VAL = HOLD_LOW;

    // Hold the event until read, then resume tracking the condition
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST_VAL;
        else if (rd_clr)
            q <= cond;
        else if (HOLD_LOW)
            q <= q & cond;
        else
            q <= q | cond;
    end

endmodule

// File: rtl/mgmt_rb_selfclr.sv
// Self-clearing bit: a set pulse raises q for exactly CYCLES clock cycles.
// A set during the countdown reloads it. Assumes CYCLES >= 1.
module mgmt_rb_selfclr #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    output logic q
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] remain;

    // Load on set, count down to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (set)
            remain <= LOAD;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    // Bit is high while cycles remain
    always_comb q = (remain != '0);

endmodule

// File: rtl/mgmt_reg_bank.sv
// Management register bank. Decodes a parallel register access from a
// serial management slave, applies per-bit access classes on writes and
// returns combinational read data. Assumes wr_en and rd_en are one-cycle
// strobes qualified by the slave; straps are stable during reset.
module mgmt_reg_bank
    import mgmt_rb_pkg::*;
#(
    parameter logic [15:0] ID_HI     = 16'h0A3C,
    parameter logic [15:0] ID_LO     = 16'h5D41,
    parameter logic [4:0]  ABILITY   = 5'b11010,
    parameter int          SC_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              addr_valid,
    input  logic              link_up,
    input  logic              rem_fault,
    input  logic              jabber,
    input  logic              aneg_done,
    input  logic              strap_speed,
    input  logic              strap_duplex,
    input  logic              strap_aneg,
    output logic [DATA_W-1:0] ctl_word,
    output logic [DATA_W-1:0] ext_word
);

    localparam logic [DATA_W-1:0] CTL_STORE_MASK = CTL_RW_MASK | CTL_CW_MASK;

    reg_sel_e          sel;
    logic              wr_ctl, wr_ext, rd_stat, rd_sum;
    logic [DATA_W-1:0] ctl_q, ext_q, ctl_wmask, ctl_rst;
    logic [DATA_W-1:0] sc_bits;
    logic [N_LAT-1:0]  lat_cond, lat_clr, lat_q;

    mgmt_rb_decode u_dec (
        .addr  (addr),
        .sel   (sel),
        .valid (addr_valid)
    );

    // Strobes qualified by the decoded register
    always_comb begin
        wr_ctl  = wr_en && (sel == SEL_CTL);
        wr_ext  = wr_en && (sel == SEL_EXT);
        rd_stat = rd_en && (sel == SEL_STAT);
        rd_sum  = rd_en && (sel == SEL_SUM);
    end

    // Writable mask of the control word: override gates the command bits
    always_comb begin
        ctl_wmask = CTL_RW_MASK | (ext_q[EXT_OVR] ? CTL_CW_MASK : '0);
    end

    // Reset image of the control word with strap-loaded fields
    always_comb begin
        ctl_rst            = '0;
        ctl_rst[CTL_SPEED] = strap_speed;
        ctl_rst[CTL_ANEN]  = strap_aneg;
        ctl_rst[CTL_DUP]   = strap_duplex;
    end

    // Control word storage: masked update keeps RO and write-zero bits at 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= ctl_rst;
        else if (wr_ctl)
            ctl_q <= ((ctl_q & ~ctl_wmask) | (wdata & ctl_wmask)) & CTL_STORE_MASK;
    end

    // Extended control storage: only read/write bits are kept
    always_ff @(posedge clk) begin
        if (!rst_n)
            ext_q <= '0;
        else if (wr_ext)
            ext_q <= wdata & EXT_RW_MASK;
    end

    // One self-clearing timer per bit named in the mask
    for (genvar i = 0; i < DATA_W; i++) begin : g_sc
        if (CTL_SC_MASK[i]) begin : g_on
            mgmt_rb_selfclr #(.CYCLES(SC_CYCLES)) u_sc (
                .clk   (clk),
                .rst_n (rst_n),
                .set   (wr_ctl && wdata[i]),
                .q     (sc_bits[i])
            );
        end else begin : g_off
            assign sc_bits[i] = 1'b0;
        end
    end

    // Latch inputs: condition and clearing read for each slot
    always_comb begin
        lat_cond = {jabber, link_up, rem_fault, link_up};
        lat_clr  = {rd_sum, rd_sum, rd_stat, rd_stat};
    end

    // One event latch per slot, polarity chosen by the package mask
    for (genvar j = 0; j < N_LAT; j++) begin : g_lat
        mgmt_rb_latch #(.HOLD_LOW(LAT_HOLD_LOW[j])) u_lat (
            .clk    (clk),
            .rst_n  (rst_n),
            .cond   (lat_cond[j]),
            .rd_clr (lat_clr[j]),
            .q      (lat_q[j])
        );
    end

    // Visible register words
    always_comb begin
        ctl_word = (ctl_q & CTL_STORE_MASK) | sc_bits;
        ext_word = ext_q;
    end

    // Read multiplexer, zero for unimplemented addresses
    always_comb begin
        case (sel)
            SEL_CTL:  rdata = ctl_word;
            SEL_STAT: rdata = {ABILITY, 5'b0, aneg_done, lat_q[1], 1'b0, lat_q[0], 2'b0};
            SEL_IDH:  rdata = ID_HI;
            SEL_IDL:  rdata = ID_LO;
            SEL_EXT:  rdata = ext_word;
            SEL_SUM:  rdata = {link_up, aneg_done, 12'b0, lat_q[3], lat_q[2]};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/mgmt_reg_bank_chk.sv
// Checker for the management register bank, bound to every instance.
// Relates the port-level behaviour across clock cycles.
module mgmt_reg_bank_chk #(
    parameter logic [15:0] ID_HI = 16'h0A3C,
    parameter logic [15:0] ID_LO = 16'h5D41
) (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  addr,
    input logic [15:0] wdata,
    input logic        wr_en,
    input logic        rd_en,
    input logic [15:0] rdata,
    input logic        addr_valid,
    input logic        link_up,
    input logic        rem_fault,
    input logic [15:0] ctl_word,
    input logic [15:0] ext_word
);

    localparam logic [15:0] NON_SC = 16'h7DFF;

    // R1: holes in the map read as zero
    assert_unimpl_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> rdata == 16'h0);

    // R1: a write to a hole leaves the stored words alone
    assert_unimpl_wr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr_valid) |=> ((ctl_word & NON_SC) == ($past(ctl_word) & NON_SC))
                                    && $stable(ext_word));

    // R2: identifier words are constant
    assert_id_const_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 5'd2 |-> rdata == ID_HI) and (addr == 5'd3 |-> rdata == ID_LO));

    // R3: command bit is locked while override is clear
    assert_cw_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 5'd0 && !ext_word[15]) |=> $stable(ctl_word[12]));

    // R4: write-zero-only bits never read one
    assert_rw0_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_word[7] && !ext_word[11]);

    // R5: an unread low link is held low
    assert_ll_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_up && !(rd_en && addr == 5'd1)) |=> (addr != 5'd1 || !rdata[2]));

    // R6: an unread fault is held high
    assert_lh_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_fault && !(rd_en && addr == 5'd1)) |=> (addr != 5'd1 || rdata[4]));

    // R7: a self-clearing bit only rises after a write of one
    assert_sc_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_word[15]) |-> $past(wr_en && addr == 5'd0 && wdata[15]));

endmodule

bind mgmt_reg_bank mgmt_reg_bank_chk #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wdata      (wdata),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rdata      (rdata),
    .addr_valid (addr_valid),
    .link_up    (link_up),
    .rem_fault  (rem_fault),
    .ctl_word   (ctl_word),
    .ext_word   (ext_word)
);

// File: tb/sim_mgmt_reg_bank.sv
// Bench for the management register bank: directed corner cases then
// seeded random traffic, all compared against a cycle model in the bench.
module sim_mgmt_reg_bank;

    localparam int          SC  = 5;
    localparam logic [15:0] IDH = 16'h0A3C;
    localparam logic [15:0] IDL = 16'h5D41;
    localparam logic [4:0]  ABL = 5'b11010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  b_addr = '0;
    logic [15:0] b_wdata = '0;
    logic        b_wr = 1'b0, b_rd = 1'b0;
    logic        b_link = 1'b1, b_rf = 1'b0, b_jab = 1'b0, b_and = 1'b0;
    logic        s_speed = 1'b1, s_dup = 1'b0, s_aneg = 1'b1;
    logic [15:0] rdata, ctl_word, ext_word;
    logic        addr_valid;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // Model state
    logic       m_loop, m_speed, m_anen, m_dup, m_ovr;
    logic [7:0] m_cfg;
    logic [3:0] m_lat;
    int         m_sc15, m_sc9;
    logic [15:0] last_rdata;
    logic        last_valid;

    always #2 clk = ~clk;

    mgmt_reg_bank #(.ID_HI(IDH), .ID_LO(IDL), .ABILITY(ABL), .SC_CYCLES(SC)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(b_addr), .wdata(b_wdata), .wr_en(b_wr),
        .rd_en(b_rd), .rdata(rdata), .addr_valid(addr_valid), .link_up(b_link),
        .rem_fault(b_rf), .jabber(b_jab), .aneg_done(b_and), .strap_speed(s_speed),
        .strap_duplex(s_dup), .strap_aneg(s_aneg), .ctl_word(ctl_word), .ext_word(ext_word)
    );

    function automatic logic [15:0] exp_ctl();
        return {m_sc15 > 0, m_loop, m_speed, m_anen, 2'b0, m_sc9 > 0, m_dup, 8'b0};
    endfunction

    function automatic logic [15:0] exp_ext();
        return {m_ovr, 7'b0, m_cfg};
    endfunction

    function automatic logic exp_valid(logic [4:0] a);
        return a inside {5'd0, 5'd1, 5'd2, 5'd3, 5'd16, 5'd17};
    endfunction

    function automatic logic [15:0] exp_rd(logic [4:0] a);
        case (a)
            5'd0:    return exp_ctl();
            5'd1:    return {ABL, 5'b0, b_and, m_lat[1], 1'b0, m_lat[0], 2'b0};
            5'd2:    return IDH;
            5'd3:    return IDL;
            5'd16:   return exp_ext();
            5'd17:   return {b_link, b_and, 12'b0, m_lat[3], m_lat[2]};
            default: return 16'h0;
        endcase
    endfunction

    function automatic string tag_rd(logic [4:0] a);
        case (a)
            5'd0, 5'd16: return "R4";
            5'd1, 5'd17: return "R5";
            5'd2, 5'd3:  return "R2";
            default:     return "R1";
        endcase
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // One clock: compare outputs with the model, then advance the model
    task automatic step();
        #1;
        last_rdata = rdata;
        last_valid = addr_valid;
        if (rst_n) begin
            chk(tag_rd(b_addr), rdata, exp_rd(b_addr));
            chk("R1", {15'b0, addr_valid}, {15'b0, exp_valid(b_addr)});
            if ((ctl_word ^ exp_ctl()) & 16'h8200) chk("R7", ctl_word, exp_ctl());
            else if ((ctl_word ^ exp_ctl()) & 16'h1000) chk("R3", ctl_word, exp_ctl());
            else chk("R4", ctl_word, exp_ctl());
            chk("R4", ext_word, exp_ext());
        end
        @(posedge clk);
        if (!rst_n) begin
            m_loop = 0; m_speed = s_speed; m_anen = s_aneg; m_dup = s_dup;
            m_ovr = 0; m_cfg = 0; m_lat = 4'b0101; m_sc15 = 0; m_sc9 = 0;
        end else begin
            logic r1, r17, wc;
            r1  = b_rd && b_addr == 5'd1;
            r17 = b_rd && b_addr == 5'd17;
            wc  = b_wr && b_addr == 5'd0;
            m_lat[0] = r1  ? b_link : (m_lat[0] & b_link);
            m_lat[1] = r1  ? b_rf   : (m_lat[1] | b_rf);
            m_lat[2] = r17 ? b_link : (m_lat[2] & b_link);
            m_lat[3] = r17 ? b_jab  : (m_lat[3] | b_jab);
            if (wc && b_wdata[15]) m_sc15 = SC; else if (m_sc15 > 0) m_sc15--;
            if (wc && b_wdata[9])  m_sc9  = SC; else if (m_sc9 > 0)  m_sc9--;
            if (wc) begin
                m_loop = b_wdata[14]; m_speed = b_wdata[13]; m_dup = b_wdata[8];
                if (m_ovr) m_anen = b_wdata[12];
            end
            if (b_wr && b_addr == 5'd16) begin
                m_ovr = b_wdata[15]; m_cfg = b_wdata[7:0];
            end
        end
        @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        b_addr = a; b_wdata = d; b_wr = 1'b1; b_rd = 1'b0;
        step();
        b_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a);
        b_addr = a; b_rd = 1'b1; b_wr = 1'b0;
        step();
        b_rd = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Watchdog: a hung run is a failure and still reports
    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int cnt;
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;
        // R8: reset image with straps speed=1, duplex=0, aneg=1
        b_addr = 5'd0; step();
        chk("R8", ctl_word, 16'h3000);
        chk("R8", ext_word, 16'h0000);
        rd(5'd1);
        chk("R8", last_rdata & 16'h0014, 16'h0004);

        // R9: read data follows address without a strobe or edge
        b_addr = 5'd2; #1 chk("R9", rdata, IDH); step();
        b_and = 1'b1; b_addr = 5'd17; #1 chk("R9", rdata & 16'hC000, 16'hC000); step();

        // R2: writes to read-only words have no effect
        wr(5'd2, 16'h0000); rd(5'd2); chk("R2", last_rdata, IDH);
        wr(5'd1, 16'hFFFF); rd(5'd1); chk("R2", last_rdata[15:11], {11'b0, ABL});

        // R3: command bit locked without override, free with it
        wr(5'd0, 16'h0000); chk("R3", {15'b0, ctl_word[12]}, 16'h1);
        wr(5'd16, 16'h8000);
        wr(5'd0, 16'h0000); chk("R3", {15'b0, ctl_word[12]}, 16'h0);
        wr(5'd0, 16'h1000); chk("R3", {15'b0, ctl_word[12]}, 16'h1);

        // R4: read/write and write-zero-only bits
        wr(5'd0, 16'h7DFF); chk("R4", ctl_word & 16'h7DFF, 16'h7100);
        wr(5'd16, 16'hFFFF); chk("R4", ext_word, 16'h80FF);
        idle(SC + 1);

        // R7: self-clear duration, write of zero, restart
        wr(5'd0, 16'h8000);
        cnt = 0;
        while (ctl_word[15] && cnt < 50) begin cnt++; step(); end
        chk("R7", 16'(cnt), 16'(SC));
        wr(5'd0, 16'h8200); idle(1);
        wr(5'd0, 16'h0000); chk("R7", ctl_word & 16'h8200, 16'h8200);
        wr(5'd0, 16'h8000);
        cnt = 0;
        while (ctl_word[15] && cnt < 50) begin cnt++; step(); end
        chk("R7", 16'(cnt), 16'(SC));

        // R5: short link drop is held until read, then live again
        b_link = 1'b1; rd(5'd1);
        b_link = 1'b0; step(); b_link = 1'b1; step();
        rd(5'd1); chk("R5", last_rdata & 16'h0004, 16'h0000);
        rd(5'd1); chk("R5", last_rdata & 16'h0004, 16'h0004);
        // R5: drop in the read cycle itself
        b_link = 1'b0; rd(5'd1); chk("R5", last_rdata & 16'h0004, 16'h0004);
        rd(5'd1); chk("R5", last_rdata & 16'h0004, 16'h0000);
        rd(5'd17); chk("R5", last_rdata & 16'h0001, 16'h0000);
        b_link = 1'b1; rd(5'd17); rd(5'd17); chk("R5", last_rdata & 16'h0001, 16'h0001);

        // R6: fault and jabber pulses held high until read
        b_rf = 1'b1; b_jab = 1'b1; step(); b_rf = 1'b0; b_jab = 1'b0; step();
        rd(5'd1); chk("R6", last_rdata & 16'h0010, 16'h0010);
        rd(5'd1); chk("R6", last_rdata & 16'h0010, 16'h0000);
        rd(5'd17); chk("R6", last_rdata & 16'h0002, 16'h0002);
        rd(5'd17); chk("R6", last_rdata & 16'h0002, 16'h0000);
        b_rf = 1'b1; rd(5'd1); b_rf = 1'b0; rd(5'd1);
        chk("R6", last_rdata & 16'h0010, 16'h0010);

        // R1: unimplemented addresses
        rd(5'd5); chk("R1", {last_valid, last_rdata[14:0]}, 16'h0);
        wr(5'd18, 16'hFFFF); wr(5'd31, 16'h0000); wr(5'd4, 16'hFFFF);
        chk("R1", ext_word, exp_ext());

        // Random phase, fixed seed
        void'($urandom(32'd2024));
        for (int n = 0; n < 4000; n++) begin
            int sel;
            logic [4:0] a;
            sel = int'($urandom % 8);
            case (sel)
                0: a = 5'd0;  1: a = 5'd1;  2: a = 5'd2; 3: a = 5'd3;
                4: a = 5'd16; 5: a = 5'd17; default: a = 5'($urandom);
            endcase
            if ($urandom % 8 == 0) b_link = ~b_link;
            if ($urandom % 8 == 0) b_rf   = ~b_rf;
            if ($urandom % 8 == 0) b_jab  = ~b_jab;
            if ($urandom % 8 == 0) b_and  = ~b_and;
            case ($urandom % 3)
                0: wr(a, 16'($urandom));
                1: rd(a);
                default: begin b_addr = a; step(); end
            endcase
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule